// File: doc/BRIEF.md
# Remote Command Frame Validator

This block sits behind the analog front end of an infrared remote-control receiver. It takes a clean digital event line that pulses for one clock cycle each time a transmitter burst is detected. It rebuilds a serial command frame from the spacing between those events. Every frame has to pass a set of independent timing and integrity checks before its command is released. Any frame that fails one check is dropped without a trace, and the receiver goes back to waiting for a new frame.

A frame starts with a start pulse. A reference pulse follows, and its distance from the start pulse sets the unit period T. Eleven data pulses come next, and each one carries one bit in its distance from the pulse before it. A stop pulse placed after a quiet gap closes the frame. An accepted frame with a non-zero command produces a one-cycle command strobe. An accepted frame whose command field is all zero is the end-of-transmission code. The block also flags end of transmission by itself when commands stop arriving for a programmable number of cycles.

Top module: `rcv_frame_validator`

## Requirements
- R1: While reset is high and in the cycle after it, `cmd_valid` and `eot` are 0 and `cmd_out` is 0.
- R2: A frame that passes every check and carries a non-zero command gives exactly one `cmd_valid` pulse, one cycle wide, in the cycle after the clock edge that samples the stop pulse. In that same cycle `cmd_out` takes the command, whose first-received bit is the MSB. `cmd_out` changes at no other time.
- R3: The distance from the start pulse to the reference pulse becomes T only if T_MIN <= T <= T_MAX. Any other distance drops the frame.
- R4: A data interval within T +/- floor(T/4) decodes as 0, and one within 2T +/- floor(T/4) decodes as 1. Both bounds are inclusive. An interval one cycle beyond either window drops the frame.
- R5: The eleven data bits are 4 address bits (MSB first), 6 command bits (MSB first) and a parity bit. The total number of ones among them must be even, or the frame is dropped.
- R6: A frame whose 4-bit address differs from the ADDR parameter (default 9) is dropped.
- R7: The stop pulse must fall within 3T +/- floor(T/4) of the parity pulse. Any pulse before that window drops the frame.
- R8: An extra pulse inside a frame that lands outside every expected window drops the frame.
- R9: An accepted frame with command 000000 gives one `eot` pulse in place of `cmd_valid`, and `cmd_out` keeps its value. `cmd_valid` and `eot` are never high together.
- R10: If no accepted frame follows a `cmd_valid` pulse, `eot` pulses exactly EOT_CYCLES cycles after it, one time only. No timeout is pending after an end-of-transmission code or after a timeout.
- R11: After any dropped frame the receiver hunts for a new start pulse, so a following correct frame is accepted.
- R12: If the next data pulse has not arrived by 2T + floor(T/4) cycles, the frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | One-cycle event for each detected burst |
| cmd_out | output | 6 | Last accepted command |
| cmd_valid | output | 1 | One-cycle strobe for an accepted non-zero command |
| eot | output | 1 | One-cycle end-of-transmission strobe (code or timeout) |

## Verification
The assertions assume that `pulse_in` is a one-cycle event and that reset is held at start-up. Under those conditions the strobes never overlap, every strobe lasts one cycle, and a latched period always lies within its legal range. The bench raises `pulse_in` for exactly one cycle per event and gives each data gap an exact cycle count. After every frame it waits longer than the widest window, 3T_MAX plus tolerance, so each frame begins from the hunting state. Before the rejection sequences it sends an end-of-transmission frame, so that no timeout can be pending and every `eot` strobe it sees can be attributed.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    localparam int ADDR_BITS  = 4;
    localparam int CMD_BITS   = 6;
    localparam int FRAME_BITS = ADDR_BITS + CMD_BITS + 1;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_MEASURE,
        ST_BITS,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_ONE,
        GAP_TWO,
        GAP_THREE
    } gap_class_e;

    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic [CMD_BITS-1:0]  cmd;
        logic                 par;
    } frame_t;

    function automatic logic parity_even(input frame_t f);
        return (^f) == 1'b0;
    endfunction

endpackage

// File: rtl/rcv_gap_counter.sv
module rcv_gap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    output logic [CNT_W-1:0] gap
);
    localparam logic [CNT_W-1:0] GAP_SAT = '1;

    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_SAT;
        end else if (pulse) begin
            gap_q <= CNT_W'(1);
        end else if (gap_q != GAP_SAT) begin
            gap_q <= gap_q + CNT_W'(1);
        end
    end

    assign gap = gap_q;

endmodule

// File: rtl/rcv_gap_classifier.sv
module rcv_gap_classifier
    import rcv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] t_unit,
    input  logic [CNT_W-1:0] gap,
    output gap_class_e       cls,
    output logic [2:0]       late
);
    localparam int WIN_W = CNT_W + 2;

    logic [WIN_W-1:0] t_w;
    logic [WIN_W-1:0] tol_w;
    logic [WIN_W-1:0] gap_w;
    logic [2:0]       hit;

    assign t_w   = {2'b00, t_unit};
    assign tol_w = t_w >> 2;
    assign gap_w = {2'b00, gap};

    for (genvar k = 0; k < 3; k++) begin : g_win
        logic [WIN_W-1:0] centre;
        logic [WIN_W-1:0] lo;
        logic [WIN_W-1:0] hi;
        assign centre = t_w * WIN_W'(k + 1);
        assign lo     = centre - tol_w;
        assign hi     = centre + tol_w;
        assign hit[k]  = (gap_w >= lo) && (gap_w <= hi);
        assign late[k] = gap_w > hi;
    end

    always_comb begin
        if (hit[0])      cls = GAP_ONE;
        else if (hit[1]) cls = GAP_TWO;
        else if (hit[2]) cls = GAP_THREE;
        else             cls = GAP_NONE;
    end

endmodule

// File: rtl/rcv_frame_fsm.sv
module rcv_frame_fsm
    import rcv_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_MIN = 8,
    parameter int T_MAX = 32,
    parameter int ADDR  = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse,
    input  logic [CNT_W-1:0]    gap,
    input  gap_class_e          cls,
    input  logic [2:0]          late,
    output logic [CNT_W-1:0]    t_unit,
    output rx_state_e           state,
    output logic                ok_cmd,
    output logic                ok_eot,
    output logic                cmd_valid_q,
    output logic                eot_code_q,
    output logic [CMD_BITS-1:0] cmd_q
);
    localparam int NB_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0]     T_LO      = CNT_W'(T_MIN);
    localparam logic [CNT_W-1:0]     T_HI      = CNT_W'(T_MAX);
    localparam logic [ADDR_BITS-1:0] ADDR_C    = ADDR_BITS'(ADDR);
    localparam logic [NB_W-1:0]      LAST_BIT  = NB_W'(FRAME_BITS - 1);

    rx_state_e             state_q, state_d;
    logic [CNT_W-1:0]      t_q, t_d;
    logic [FRAME_BITS-1:0] sh_q, sh_d;
    logic [NB_W-1:0]       nb_q, nb_d;
    frame_t                frm;

    assign frm = frame_t'(sh_q);

    always_comb begin
        state_d = state_q;
        t_d     = t_q;
        sh_d    = sh_q;
        nb_d    = nb_q;
        ok_cmd  = 1'b0;
        ok_eot  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (pulse) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (pulse) begin
                    if (gap >= T_LO && gap <= T_HI) begin
                        t_d     = gap;
                        nb_d    = '0;
                        state_d = ST_BITS;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end else if (gap > T_HI) begin
                    state_d = ST_HUNT;
                end
            end
            ST_BITS: begin
                if (pulse) begin
                    if (cls == GAP_ONE || cls == GAP_TWO) begin
                        sh_d = {sh_q[FRAME_BITS-2:0], (cls == GAP_TWO)};
                        nb_d = nb_q + NB_W'(1);
                        if (nb_q == LAST_BIT) state_d = ST_STOP;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end else if (late[1]) begin
                    state_d = ST_HUNT;
                end
            end
            ST_STOP: begin
                if (pulse) begin
                    state_d = ST_HUNT;
                    if (cls == GAP_THREE && frm.addr == ADDR_C && parity_even(frm)) begin
                        if (frm.cmd == '0) ok_eot = 1'b1;
                        else               ok_cmd = 1'b1;
                    end
                end else if (late[2]) begin
                    state_d = ST_HUNT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HUNT;
            t_q         <= T_LO;
            sh_q        <= '0;
            nb_q        <= '0;
            cmd_valid_q <= 1'b0;
            eot_code_q  <= 1'b0;
            cmd_q       <= '0;
        end else begin
            state_q     <= state_d;
            t_q         <= t_d;
            sh_q        <= sh_d;
            nb_q        <= nb_d;
            cmd_valid_q <= ok_cmd;
            eot_code_q  <= ok_eot;
            if (ok_cmd) cmd_q <= frm.cmd;
        end
    end

    assign t_unit = t_q;
    assign state  = state_q;

endmodule

// File: rtl/rcv_eot_timer.sv
module rcv_eot_timer #(
    parameter int EOT_CYCLES = 275000
) (
    input  logic clk,
    input  logic rst,
    input  logic ok_cmd,
    input  logic ok_eot,
    output logic eot_to
);
    localparam int EW = $clog2(EOT_CYCLES + 1);
    localparam logic [EW-1:0] LIMIT = EW'(EOT_CYCLES);

    logic          armed_q;
    logic [EW-1:0] cnt_q;
    logic          to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            to_q    <= 1'b0;
        end else begin
            to_q <= 1'b0;
            if (ok_cmd) begin
                armed_q <= 1'b1;
                cnt_q   <= EW'(1);
            end else if (ok_eot) begin
                armed_q <= 1'b0;
            end else if (armed_q) begin
                if (cnt_q == LIMIT) begin
                    to_q    <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + EW'(1);
                end
            end
        end
    end

    assign eot_to = to_q;

endmodule

// File: rtl/rcv_frame_validator.sv
module rcv_frame_validator
    import rcv_pkg::*;
#(
    parameter int T_MIN      = 64,
    parameter int T_MAX      = 512,
    parameter int ADDR       = 9,
    parameter int EOT_CYCLES = 275000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse_in,
    output logic [CMD_BITS-1:0] cmd_out,
    output logic                cmd_valid,
    output logic                eot
);
    localparam int CNT_W = $clog2(3 * T_MAX + T_MAX / 4 + 2);

    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] t_unit;
    gap_class_e       cls;
    logic [2:0]       late;
    rx_state_e        state;
    logic             ok_cmd;
    logic             ok_eot;
    logic             eot_code;
    logic             eot_to;
    logic             in_frame;

    rcv_gap_counter #(.CNT_W(CNT_W)) gap_i (
        .clk   (clk),
        .rst   (rst),
        .pulse (pulse_in),
        .gap   (gap)
    );

    rcv_gap_classifier #(.CNT_W(CNT_W)) cls_i (
        .t_unit (t_unit),
        .gap    (gap),
        .cls    (cls),
        .late   (late)
    );

    rcv_frame_fsm #(
        .CNT_W (CNT_W),
        .T_MIN (T_MIN),
        .T_MAX (T_MAX),
        .ADDR  (ADDR)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .pulse       (pulse_in),
        .gap         (gap),
        .cls         (cls),
        .late        (late),
        .t_unit      (t_unit),
        .state       (state),
        .ok_cmd      (ok_cmd),
        .ok_eot      (ok_eot),
        .cmd_valid_q (cmd_valid),
        .eot_code_q  (eot_code),
        .cmd_q       (cmd_out)
    );

    rcv_eot_timer #(.EOT_CYCLES(EOT_CYCLES)) eot_i (
        .clk    (clk),
        .rst    (rst),
        .ok_cmd (ok_cmd),
        .ok_eot (ok_eot),
        .eot_to (eot_to)
    );

    assign in_frame = (state == ST_BITS) || (state == ST_STOP);
    assign eot      = eot_code | eot_to;

endmodule

// File: rtl/rcv_frame_checker.sv
module rcv_frame_checker #(
    parameter int CNT_W = 8,
    parameter int T_MIN = 8,
    parameter int T_MAX = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             eot,
    input logic [5:0]       cmd,
    input logic             in_frame,
    input logic [CNT_W-1:0] t_unit
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(T_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(T_MAX);

    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && eot));

    assert_code_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd != 6'd0));

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd) |-> cmd_valid);

    assert_eot_single_R10: assert property (@(posedge clk) disable iff (rst)
        eot |=> !eot);

    assert_period_range_R3: assert property (@(posedge clk) disable iff (rst)
        in_frame |-> (t_unit >= LO && t_unit <= HI));

endmodule

bind rcv_frame_validator rcv_frame_checker #(
    .CNT_W (CNT_W),
    .T_MIN (T_MIN),
    .T_MAX (T_MAX)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .eot       (eot),
    .cmd       (cmd_out),
    .in_frame  (in_frame),
    .t_unit    (t_unit)
);

// File: tb/rcv_frame_validator_tb.sv
module rcv_frame_validator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TMIN = 8;
    localparam int TMAX = 32;
    localparam int ADR  = 9;
    localparam int EOTC = 3000;
    localparam int IDLE = 150;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse = 1'b0;
    logic [5:0] cmd_out;
    logic       cmd_valid;
    logic       eot;

    int nchecks = 0;
    int nfail = 0;
    int nvalid = 0;
    int neot = 0;
    int last_cmd = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rcv_frame_validator #(
        .T_MIN (TMIN),
        .T_MAX (TMAX),
        .ADDR  (ADR),
        .EOT_CYCLES (EOTC)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pulse_in  (pulse),
        .cmd_out   (cmd_out),
        .cmd_valid (cmd_valid),
        .eot       (eot)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) begin
                nvalid++;
                last_cmd = int'(cmd_out);
            end
            if (eot) neot++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire();
        pulse = 1'b1;
        @(negedge clk);
        pulse = 1'b0;
    endtask

    task automatic after_gap(input int d);
        repeat (d - 1) @(negedge clk);
        fire();
    endtask

    task automatic send_frame(input int t, input logic [3:0] a, input logic [5:0] c,
                              input logic par_flip, input int dev, input int nbits,
                              input int noise_after, input logic quiet_hit,
                              input int stop_dev, input int idle);
        logic [10:0] bits;
        bits = {a, c, (^{a, c}) ^ par_flip};
        fire();
        after_gap(t);
        for (int i = 0; i < nbits; i++) begin
            after_gap((bits[10 - i] ? 2 * t : t) + dev);
            if (noise_after == i) after_gap(2);
        end
        if (nbits == 11) begin
            if (quiet_hit) after_gap(t);
            after_gap(3 * t + stop_dev);
        end
        repeat (idle) @(negedge clk);
        #1;
    endtask

    task automatic frame_expect(input string req, input int t, input logic [3:0] a,
                                input logic [5:0] c, input logic par_flip, input int dev,
                                input int nbits, input int noise_after, input logic quiet_hit,
                                input int stop_dev, input int exp_valid, input int exp_eot);
        int v0;
        int e0;
        int c0;
        v0 = nvalid;
        e0 = neot;
        c0 = int'(cmd_out);
        send_frame(t, a, c, par_flip, dev, nbits, noise_after, quiet_hit, stop_dev, IDLE);
        check({req, " valid strobes"}, nvalid - v0, exp_valid);
        check({req, " eot strobes"}, neot - e0, exp_eot);
        if (exp_valid == 1) check({req, " command"}, last_cmd, int'(c));
        else check({req, " command held"}, int'(cmd_out), c0);
    endtask

    initial begin
        repeat (EOT_CYCLES_WD()) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    function automatic int EOT_CYCLES_WD();
        return 190000;
    endfunction

    initial begin
        int k;
        int e0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 cmd_valid in reset", int'(cmd_valid), 0);
        check("R1 eot in reset", int'(eot), 0);
        check("R1 cmd_out in reset", int'(cmd_out), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 cmd_valid after reset", int'(cmd_valid), 0);
        check("R1 eot after reset", int'(eot), 0);

        // R2 / R9: sweep every command code; code 0 is the end-of-transmission code
        for (int c = 0; c < 64; c++) begin
            if (c == 0) frame_expect("R9 code eot", 16, 4'd9, 6'd0, 0, 0, 11, -1, 0, 0, 0, 1);
            else        frame_expect("R2 sweep",    16, 4'd9, 6'(c), 0, 0, 11, -1, 0, 0, 1, 0);
        end

        // R3 / R4: period range limits and tolerance edges
        frame_expect("R3 T at minimum", TMIN, 4'd9, 6'h2A, 0, 0, 11, -1, 0, 0, 1, 0);
        frame_expect("R3 T at maximum", TMAX, 4'd9, 6'h15, 0, 0, 11, -1, 0, 0, 1, 0);
        frame_expect("R4 T16 dev +4",   16, 4'd9, 6'h33, 0,  4, 11, -1, 0, 0, 1, 0);
        frame_expect("R4 T16 dev -4",   16, 4'd9, 6'h0C, 0, -4, 11, -1, 0, 0, 1, 0);
        frame_expect("R4 T13 dev +3",   13, 4'd9, 6'h27, 0,  3, 11, -1, 0, 0, 1, 0);
        frame_expect("R4 T13 dev -3",   13, 4'd9, 6'h18, 0, -3, 11, -1, 0, 0, 1, 0);
        frame_expect("R7 stop +4",      16, 4'd9, 6'h01, 0, 0, 11, -1, 0, 4, 1, 0);
        frame_expect("R7 stop -4",      16, 4'd9, 6'h3F, 0, 0, 11, -1, 0, -4, 1, 0);

        // disarm the timeout before rejection sequences
        frame_expect("R9 code eot keeps cmd", 16, 4'd9, 6'd0, 0, 0, 11, -1, 0, 0, 0, 1);

        // R6: every other address is dropped
        for (int a = 0; a < 16; a++) begin
            if (a != ADR) frame_expect("R6 address", 16, 4'(a), 6'h11, 0, 0, 11, -1, 0, 0, 0, 0);
        end

        frame_expect("R5 odd parity",   16, 4'd9, 6'h11, 1, 0, 11, -1, 0, 0, 0, 0);
        frame_expect("R5 odd parity b", 16, 4'd9, 6'h00, 1, 0, 11, -1, 0, 0, 0, 0);
        frame_expect("R3 T too long",   TMAX + 1, 4'd9, 6'h11, 0, 0, 11, -1, 0, 0, 0, 0);
        frame_expect("R3 T too short",  TMIN - 1, 4'd9, 6'h11, 0, 0, 11, -1, 0, 0, 0, 0);
        frame_expect("R4 T16 dev +5",   16, 4'd9, 6'h11, 0,  5, 11, -1, 0, 0, 0, 0);
        frame_expect("R4 T16 dev -5",   16, 4'd9, 6'h11, 0, -5, 11, -1, 0, 0, 0, 0);
        frame_expect("R4 T13 dev +4",   13, 4'd9, 6'h11, 0,  4, 11, -1, 0, 0, 0, 0);
        frame_expect("R4 T13 dev -4",   13, 4'd9, 6'h11, 0, -4, 11, -1, 0, 0, 0, 0);
        frame_expect("R7 stop +5",      16, 4'd9, 6'h11, 0, 0, 11, -1, 0, 5, 0, 0);
        frame_expect("R7 stop -5",      16, 4'd9, 6'h11, 0, 0, 11, -1, 0, -5, 0, 0);
        frame_expect("R7 quiet gap hit", 16, 4'd9, 6'h11, 0, 0, 11, -1, 1, 0, 0, 0);
        frame_expect("R8 noise in bits", 16, 4'd9, 6'h11, 0, 0, 11, 3, 0, 0, 0, 0);
        frame_expect("R8 noise at end",  16, 4'd9, 6'h11, 0, 0, 11, 10, 0, 0, 0, 0);
        frame_expect("R12 missing pulse", 16, 4'd9, 6'h11, 0, 0, 5, -1, 0, 0, 0, 0);

        // R11: receiver recovers, then R10 timeout measured from this strobe
        send_frame(16, 4'd9, 6'h2D, 0, 0, 11, -1, 0, 0, 0);
        check("R11 recovered frame strobe", int'(cmd_valid), 1);
        check("R11 recovered command", int'(cmd_out), 6'h2D);
        k = 0;
        for (int i = 1; i <= EOTC + 10; i++) begin
            @(negedge clk);
            #1;
            if (eot) begin
                k = i;
                break;
            end
        end
        check("R10 timeout distance", k, EOTC);
        e0 = neot;
        repeat (2 * EOTC) @(negedge clk);
        #1;
        check("R10 single timeout", neot - e0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule